// File: doc/BRIEF.md
# Task-Aware Delayed Branch Unit

On a multi-task pipeline a delayed jump, call or return has to run three trailing instructions of its own task before control moves to the target. Instructions from several tasks can be interleaved in the pipeline, so the three instructions that follow a branch in the pipe may belong to other tasks. This unit makes the branch wait for three same-task instructions, whatever the task mix. Code written with three delay slots for a single task therefore also runs correctly when tasks are interleaved.

The decode stage raises a branch request that carries the task ID, the resolved target and the task IDs held in the lower pipeline stages. The unit works out how many same-task instructions are still missing behind the branch. It stores the target in that task's pending register and counts later same-task instructions on the issue stream until the shortfall is made up. It then pulses a redirect strobe for that task together with the stored target. Each task has its own pending slot, and all slots work at the same time. Jumps, calls and returns share one path, because the unit only sees a target.

Top module: `dbranch_unit`

## Requirements
- R1: After a synchronous active-low reset, no task has a pending branch and all bits of `redir_valid` are 0.
- R2: On an accepted request the deficit is 3 minus the number of lower stages `i` with `stg_valid[i]` set and `stg_task[2*i+1:2*i]` equal to `br_task`. Invalid stages never count.
- R3: If the deficit is 0, `redir_valid[br_task]` is 1 in the cycle right after the request, with `redir_target[16*t+15:16*t]` equal to the requested target.
- R4: If the deficit is d > 0, the redirect comes in the cycle after the d-th later cycle with `ret_valid` high and `ret_task` equal to the branch's task. Before that it stays 0.
- R5: Issue-stream instructions from other tasks never advance a pending branch.
- R6: The target is captured when the request is accepted and stays unchanged until the redirect, whatever later values `br_target` takes.
- R7: A request from a task whose branch is still pending is ignored, and this includes the cycle in which its redirect is shown.
- R8: The four tasks' slots are independent. Two or more tasks may redirect in the same cycle, each with its own target.
- R9: A same-task issue in the cycle of the request itself does not reduce the deficit.
- R10: A redirect lasts exactly one cycle. The task is idle afterwards and accepts a new request in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_valid | input | 1 | Delayed branch request |
| br_task | input | 2 | Task ID of the branch |
| br_target | input | 16 | Resolved branch target |
| stg_valid | input | 3 | Valid bits of the lower pipeline stages |
| stg_task | input | 6 | Task IDs of the lower stages, 2 bits per stage |
| ret_valid | input | 1 | A new instruction entered behind the branch stage |
| ret_task | input | 2 | Task ID of that instruction |
| redir_valid | output | 4 | Per-task PC redirect strobe |
| redir_target | output | 64 | Per-task redirect target, 16 bits per task |

## Verification
Every result of this unit is due exactly one clock edge after the input that causes it. A zero-deficit request redirects after the edge that accepts it. A pending branch redirects after the edge that takes its last missing same-task issue. The bench drives inputs 2 ns after a rising edge and reads the outputs at that same point after the following edge, so each check sees the state produced by one edge. In the cycles before a redirect is due, the bench checks that `redir_valid` is still 0, so an early redirect is caught as well as a late one.

// File: rtl/dbu_pkg.sv
// Shared constants for the delayed branch unit.
// Assumes: the trailing-slot count is small (fits a few bits).
package dbu_pkg;
    localparam int TRAIL_SLOTS = 3;
    localparam int TRAIL_CNT_W = $clog2(TRAIL_SLOTS + 1);
endpackage

// File: rtl/dbu_depth.sv
// Computes the trailing-instruction deficit of a new branch: the slot
// count minus the lower stages that already hold the branch's task.
// Assumes: stage task IDs are packed TID_W bits per stage, stage 0 lowest.
module dbu_depth #(
    parameter int N_STG = 3,
    parameter int TID_W = 2,
    parameter int TRAIL = 3,
    parameter int CNT_W = 2
) (
    input  logic [N_STG-1:0]       stg_valid,
    input  logic [N_STG*TID_W-1:0] stg_task,
    input  logic [TID_W-1:0]       req_task,
    output logic [CNT_W-1:0]       deficit
);
    int hits;

    // Count valid same-task stages and turn the count into a saturated deficit.
    always_comb begin
        hits = 0;
        for (int i = 0; i < N_STG; i++) begin
            if (stg_valid[i] && (stg_task[i*TID_W +: TID_W] == req_task)) begin
                hits = hits + 1;
            end
        end
        deficit = (hits >= TRAIL) ? '0 : CNT_W'(TRAIL - hits);
    end
endmodule

// File: rtl/dbu_slot.sv
// One task's pending delayed branch: a flag, the stored target and a
// down-counter of missing same-task instructions. The redirect is shown
// while the flag is set and the counter has reached zero.
// Assumes: load and tick are already qualified with this task's ID.
module dbu_slot #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  deficit,
    input  logic [ADDR_W-1:0] target,
    input  logic              tick,
    output logic              redir,
    output logic [ADDR_W-1:0] redir_tgt
);
    logic              pend_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] tgt_q;

    assign redir     = pend_q && (cnt_q == '0);
    assign redir_tgt = tgt_q;

    // Accept when idle, count same-task issues, and release after the redirect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
            tgt_q  <= '0;
        end else if (redir) begin
            pend_q <= 1'b0;
        end else if (pend_q) begin
            if (tick) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (load) begin
            pend_q <= 1'b1;
            cnt_q  <= deficit;
            tgt_q  <= target;
        end
    end

    p_zero_deficit_redirect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !pend_q && deficit == '0) |=> redir);

    p_last_tick_redirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && cnt_q == CNT_W'(1) && tick) |=> redir);

    p_hold_without_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && cnt_q != '0 && !tick) |=> (pend_q && $stable(cnt_q)));

    p_target_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !redir) |=> $stable(tgt_q));

    p_busy_ignores_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && load) |=> $stable(tgt_q));

    p_single_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        redir |=> !redir);
endmodule

// File: rtl/dbranch_unit.sv
// Task-aware delayed branch unit. One slot per task holds a pending
// branch until three same-task trailing instructions are guaranteed,
// then pulses that task's redirect strobe with the stored target.
// Assumes: at most one branch request and one issue per cycle.
module dbranch_unit #(
    parameter int N_TASK = 4,
    parameter int ADDR_W = 16,
    parameter int N_STG  = 3,
    parameter int TRAIL  = dbu_pkg::TRAIL_SLOTS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     br_valid,
    input  logic [$clog2(N_TASK)-1:0] br_task,
    input  logic [ADDR_W-1:0]        br_target,
    input  logic [N_STG-1:0]         stg_valid,
    input  logic [N_STG*$clog2(N_TASK)-1:0] stg_task,
    input  logic                     ret_valid,
    input  logic [$clog2(N_TASK)-1:0] ret_task,
    output logic [N_TASK-1:0]        redir_valid,
    output logic [N_TASK*ADDR_W-1:0] redir_target
);
    localparam int TID_W = $clog2(N_TASK);
    localparam int CNT_W = $clog2(TRAIL + 1);

    logic [CNT_W-1:0] deficit;

    dbu_depth #(
        .N_STG(N_STG), .TID_W(TID_W), .TRAIL(TRAIL), .CNT_W(CNT_W)
    ) i_depth (
        .stg_valid(stg_valid),
        .stg_task (stg_task),
        .req_task (br_task),
        .deficit  (deficit)
    );

    for (genvar t = 0; t < N_TASK; t++) begin : g_slot
        logic load_t;
        logic tick_t;

        // Route the request and issue stream only to the owning task's slot.
        always_comb begin
            load_t = br_valid  && (br_task  == TID_W'(t));
            tick_t = ret_valid && (ret_task == TID_W'(t));
        end

        dbu_slot #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_t),
            .deficit  (deficit),
            .target   (br_target),
            .tick     (tick_t),
            .redir    (redir_valid[t]),
            .redir_tgt(redir_target[t*ADDR_W +: ADDR_W])
        );
    end
endmodule

// File: tb/test_dbranch_unit.sv
module test_dbranch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0;
    logic [1:0]  br_task = '0;
    logic [15:0] br_target = '0;
    logic [2:0]  stg_valid = '0;
    logic [5:0]  stg_task = '0;
    logic        ret_valid = 1'b0;
    logic [1:0]  ret_task = '0;
    logic [3:0]  redir_valid;
    logic [63:0] redir_target;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbranch_unit i_dbranch_unit (
        .clk(clk), .rst_n(rst_n),
        .br_valid(br_valid), .br_task(br_task), .br_target(br_target),
        .stg_valid(stg_valid), .stg_task(stg_task),
        .ret_valid(ret_valid), .ret_task(ret_task),
        .redir_valid(redir_valid), .redir_target(redir_target)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
        br_valid  = 1'b0;
        ret_valid = 1'b0;
    endtask

    task automatic req(logic [1:0] t, logic [15:0] tg, logic [2:0] sv, logic [5:0] st);
        br_valid = 1'b1; br_task = t; br_target = tg;
        stg_valid = sv; stg_task = st;
    endtask

    task automatic issue(logic [1:0] t);
        ret_valid = 1'b1; ret_task = t;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        chk("R1 reset", 64'(redir_valid), 64'h0);
        rst_n = 1'b1;
        step();
        chk("R1 idle after reset", 64'(redir_valid), 64'h0);
    endtask

    task automatic t_zero_deficit();
        req(2'd1, 16'h1234, 3'b111, {2'd1, 2'd1, 2'd1});
        step();
        chk("R3 redirect strobe", 64'(redir_valid), 64'h2);
        chk("R3 redirect target", 64'(redir_target[31:16]), 64'h1234);
        step();
        chk("R10 strobe one cycle", 64'(redir_valid), 64'h0);
    endtask

    task automatic t_full_deficit();
        req(2'd2, 16'hBEEF, 3'b111, {2'd0, 2'd3, 2'd1});
        step();
        chk("R2 other tasks in stages give deficit 3", 64'(redir_valid), 64'h0);
        issue(2'd2); step();
        chk("R4 early after 1", 64'(redir_valid), 64'h0);
        issue(2'd0); step();
        chk("R5 other task no count", 64'(redir_valid), 64'h0);
        issue(2'd2); step();
        chk("R4 early after 2", 64'(redir_valid), 64'h0);
        issue(2'd3); step();
        chk("R5 other task no count", 64'(redir_valid), 64'h0);
        issue(2'd2); step();
        chk("R4 redirect after 3", 64'(redir_valid), 64'h4);
        chk("R4 target", 64'(redir_target[47:32]), 64'hBEEF);
    endtask

    task automatic t_valid_mask();
        req(2'd3, 16'h0A0A, 3'b101, {2'd3, 2'd3, 2'd3});
        step();
        chk("R2 invalid stage ignored, deficit 1", 64'(redir_valid), 64'h0);
        issue(2'd3); step();
        chk("R2 deficit 1 redirect", 64'(redir_valid), 64'h8);
        step();
        req(2'd3, 16'h0B0B, 3'b000, {2'd3, 2'd3, 2'd3});
        step();
        issue(2'd3); step();
        issue(2'd3); step();
        chk("R2 all invalid, no early redirect", 64'(redir_valid), 64'h0);
        issue(2'd3); step();
        chk("R2 all invalid, deficit 3", 64'(redir_valid), 64'h8);
        chk("R2 target", 64'(redir_target[63:48]), 64'h0B0B);
    endtask

    task automatic t_busy_and_hold();
        req(2'd0, 16'h5555, 3'b011, {2'd2, 2'd0, 2'd0});
        step();
        req(2'd0, 16'h9999, 3'b111, {2'd0, 2'd0, 2'd0});
        step();
        chk("R7 second request ignored", 64'(redir_valid), 64'h0);
        br_target = 16'hFFFF;
        issue(2'd0); step();
        chk("R6 redirect", 64'(redir_valid), 64'h1);
        chk("R6 target kept", 64'(redir_target[15:0]), 64'h5555);
        req(2'd0, 16'h7777, 3'b111, {2'd0, 2'd0, 2'd0});
        step();
        chk("R7 request in redirect cycle ignored", 64'(redir_valid), 64'h0);
        req(2'd0, 16'h6666, 3'b111, {2'd0, 2'd0, 2'd0});
        step();
        chk("R10 accepted right after", 64'(redir_valid), 64'h1);
        chk("R10 new target", 64'(redir_target[15:0]), 64'h6666);
    endtask

    task automatic t_same_cycle_issue();
        req(2'd1, 16'h4321, 3'b110, {2'd1, 2'd1, 2'd2});
        issue(2'd1);
        step();
        chk("R9 issue in request cycle not counted", 64'(redir_valid), 64'h0);
        issue(2'd1); step();
        chk("R9 redirect after later issue", 64'(redir_valid), 64'h2);
    endtask

    task automatic t_concurrent();
        req(2'd1, 16'h1111, 3'b110, {2'd1, 2'd1, 2'd0});
        step();
        req(2'd2, 16'h2222, 3'b111, {2'd2, 2'd2, 2'd2});
        issue(2'd1);
        step();
        chk("R8 two tasks same cycle", 64'(redir_valid), 64'h6);
        chk("R8 task1 target", 64'(redir_target[31:16]), 64'h1111);
        chk("R8 task2 target", 64'(redir_target[47:32]), 64'h2222);
    endtask

    initial begin
        #2;
        t_reset();
        t_zero_deficit();
        step();
        t_full_deficit();
        step();
        t_valid_mask();
        step();
        t_busy_and_hold();
        step();
        t_same_cycle_issue();
        step();
        t_concurrent();
        step();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule